// File: doc/BRIEF.md
# Dual-Channel Pin Edge Interrupt Unit

This block watches a bank of 28 general-purpose input pins and turns single edges on them into interrupt requests. Two channels work independently. Each channel picks one interrupt-capable pin through a compact 5-bit code, looks for either a rising or a falling edge on it, and latches a pending flag when that edge arrives. The two flags are ORed onto one interrupt line for the processor.

Software reaches the block through a small synchronous register bus. It has three word registers:
- an input-level register that shows the synchronized state of every pin;
- a control register that holds the per-channel polarity and enable bits, the write-one clear bits, the read-only pending flags and a self-clearing handshake bit;
- a select register that holds the two pin codes.

To catch both edges of a signal, software flips the polarity bit after each event.

Every pin first passes through a two-flop synchronizer. A per-pin history flop keeps the previous synchronized level. Edges are found by comparing the current and previous levels of the selected pin. Because of this, changing the polarity or the pin choice can never invent an edge.

Top module: `gpio_edge_irq`

## Requirements
- R1: A read of word address 0 returns the synchronized level of pin n in bit n, for all 28 pins. A pin change appears there on the read issued three or more clock edges after the change.
- R2: Word address 2 holds the pin code of channel c in bits [5c+4:5c]. Codes 0 to 13 select pins 0 to 13. Codes 14 to 19 select pins 22 to 27. Codes 20 to 31 select no pin, and such a channel never latches a flag.
- R3: Control bit 2+c sets the polarity of channel c: 1 detects rising edges and 0 detects falling edges. A qualifying edge makes the pending flag visible on the third clock edge after the pin change.
- R4: Control bit 6+c enables channel c. While it is 0, no new pending flag is latched, and a flag that is already set is kept.
- R5: Control bit 21+c reads as channel c's pending flag and ignores writes. Writing 1 to control bit 17+c clears that flag, and writing 0 there leaves it alone. If an edge and a clear land on the same cycle, the flag stays set.
- R6: The irq output is high exactly when at least one pending flag is set.
- R7: Changing the polarity bit or the pin code, with no pin activity, sets no pending flag.
- R8: Writing 1 to control bit 16 makes that bit read 1. It returns to 0 by itself BUSY_CYC (default 4) clock edges later.
- R9: After reset every register field reads 0 and irq is low. Control bits 17 to 20 and all unused bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 28 | Asynchronous pin levels |
| bus_addr | input | 2 | Word address: 0 levels, 1 control, 2 select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the address |
| irq | output | 1 | Combined interrupt request |

## Verification
Rising and falling pin transitions are applied under both polarities. This shows that a channel reacts only to its chosen edge and ignores the opposite one. Pins from the low range and the remapped high range are selected, and a pin is toggled that no code reaches, to confirm the code-to-pin mapping and that invalid codes are dead. Further cases are a clear write timed onto the same cycle as a new edge, polarity and code changes made while the pins are still, and edges that arrive while a channel is disabled. These cases separate set-priority from clear-priority, history-based edge detection from level comparison, and gating of new events from loss of held ones.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NPIN      = 28,
  parameter int NCH       = 2,
  parameter int SELW      = 5,
  parameter int LOW_PINS  = 14,
  parameter int HIGH_BASE = 22,
  parameter int HIGH_CNT  = 6,
  parameter int BUSY_CYC  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic [1:0]      bus_addr,
  input  logic            bus_we,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq
);
  localparam logic [1:0] A_LVL  = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_SEL  = 2'd2;
  localparam int POL_B  = 2;
  localparam int EN_B   = 6;
  localparam int BUSY_B = 16;
  localparam int CLR_B  = 17;
  localparam int PND_B  = 21;
  localparam int CW     = $clog2(BUSY_CYC + 1);
  localparam int PW     = $clog2(NPIN);

  logic [NPIN-1:0]     meta, lvl, hist;
  logic [NCH-1:0]      pol, en, pend, hit, sel_ok;
  logic [NCH*SELW-1:0] sel;
  logic [CW-1:0]       busy_cnt;
  logic [31:0]         ctrl_rd;

  wire wr_ctrl = bus_we && bus_addr == A_CTRL;
  wire wr_sel  = bus_we && bus_addr == A_SEL;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= '0; lvl <= '0; hist <= '0;
    end else begin
      meta <= pin_in; lvl <= meta; hist <= lvl;
    end

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      logic [SELW-1:0] code;
      logic [PW-1:0]   pin;
      logic            cur, prv;
      assign code = sel[c*SELW +: SELW];

      always_comb begin
        sel_ok[c] = 1'b0;
        pin = '0;
        if (int'(code) < LOW_PINS) begin
          sel_ok[c] = 1'b1;
          pin = PW'(code);
        end else if (int'(code) < LOW_PINS + HIGH_CNT) begin
          sel_ok[c] = 1'b1;
          pin = PW'(int'(code) - LOW_PINS + HIGH_BASE);
        end
      end

      assign cur    = lvl[pin];
      assign prv    = hist[pin];
      assign hit[c] = sel_ok[c] && (pol[c] ? (cur && !prv) : (!cur && prv));

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pend[c] <= 1'b0;
        else if (en[c] && hit[c]) pend[c] <= 1'b1;
        else if (wr_ctrl && bus_wdata[CLR_B+c]) pend[c] <= 1'b0;

      p_clear_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend[c]) |-> $past(bus_we && bus_addr == A_CTRL && bus_wdata[CLR_B+c]));
      p_enable_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[c]) |-> $past(en[c]));
      p_valid_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[c]) |-> $past(sel_ok[c]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pol <= '0; en <= '0; sel <= '0; busy_cnt <= '0;
    end else begin
      if (wr_ctrl) begin
        pol <= bus_wdata[POL_B +: NCH];
        en  <= bus_wdata[EN_B  +: NCH];
      end
      if (wr_sel) sel <= bus_wdata[NCH*SELW-1:0];
      if (wr_ctrl && bus_wdata[BUSY_B]) busy_cnt <= CW'(BUSY_CYC);
      else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
    end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[POL_B +: NCH] = pol;
    ctrl_rd[EN_B  +: NCH] = en;
    ctrl_rd[BUSY_B]       = busy_cnt != '0;
    ctrl_rd[PND_B +: NCH] = pend;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else case (bus_addr)
      A_LVL:   bus_rdata <= 32'(lvl);
      A_CTRL:  bus_rdata <= ctrl_rd;
      A_SEL:   bus_rdata <= 32'(sel);
      default: bus_rdata <= '0;
    endcase

  assign irq = |pend;

  p_busy_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CTRL && bus_wdata[BUSY_B]) |=> busy_cnt == CW'(BUSY_CYC));
  p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(en & hit)));
endmodule

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;
  localparam int TCLK = 10;
  localparam logic [1:0] A_LVL = 2'd0, A_CTRL = 2'd1, A_SEL = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [27:0] pin_in = '0;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int nvec = 0, nbad = 0;
  logic [31:0] rd;

  gpio_edge_irq u_dut (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #(TCLK/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rdw(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk); d = bus_rdata;
  endtask

  function automatic logic [31:0] cv(logic [1:0] pol, logic [1:0] en);
    return {24'd0, en, 2'd0, pol, 2'd0};
  endfunction

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(A_CTRL, 32'h0006_0000);
  endtask

  task automatic t_reset();
    rdw(A_LVL, rd);  chk("R9 lvl", rd, 0);
    rdw(A_CTRL, rd); chk("R9 ctrl", rd, 0);
    rdw(A_SEL, rd);  chk("R9 sel", rd, 0);
    chk("R9 irq", irq, 0);
  endtask

  task automatic t_levels();
    @(negedge clk); pin_in = 28'hA5C_3E71;
    settle(3);
    rdw(A_LVL, rd); chk("R1 levels", rd, 32'h0A5C_3E71);
    @(negedge clk); pin_in = '0;
    settle(3);
    rdw(A_LVL, rd); chk("R1 levels zero", rd, 0);
  endtask

  task automatic t_rise();
    wr(A_SEL, {22'd0, 5'd0, 5'd5});
    wr(A_CTRL, cv(2'b01, 2'b01));
    @(negedge clk); pin_in[5] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R3 not yet", irq, 0);
    @(negedge clk);
    chk("R3 rise latency", irq, 1);
    rdw(A_CTRL, rd); chk("R5 pend bit", rd[22:21], 2'b01);
    wr(A_CTRL, cv(2'b01, 2'b01) | 32'h0020_0000);
    rdw(A_CTRL, rd); chk("R5 pend read-only", rd[22:21], 2'b01);
    wr(A_CTRL, cv(2'b01, 2'b01) | 32'h0004_0000);
    chk("R5 other clear", irq, 1);
    wr(A_CTRL, cv(2'b01, 2'b01) | 32'h0002_0000);
    chk("R5 clear", irq, 0);
    @(negedge clk); pin_in[5] = 1'b0;
    settle(4);
    chk("R3 falling ignored", irq, 0);
  endtask

  task automatic t_fall();
    @(negedge clk); pin_in[9] = 1'b1;
    wr(A_SEL, {22'd0, 5'd9, 5'd0});
    wr(A_CTRL, cv(2'b00, 2'b10));
    settle(4);
    chk("R3 no event yet", irq, 0);
    @(negedge clk); pin_in[9] = 1'b0;
    settle(3);
    chk("R3 fall", irq, 1);
    rdw(A_CTRL, rd); chk("R6 ch1 flag", rd[22:21], 2'b10);
    clear_all();
    chk("R6 irq drop", irq, 0);
  endtask

  task automatic t_enable();
    wr(A_SEL, {22'd0, 5'd0, 5'd3});
    wr(A_CTRL, cv(2'b01, 2'b00));
    @(negedge clk); pin_in[3] = 1'b1;
    settle(4);
    chk("R4 disabled", irq, 0);
    @(negedge clk); pin_in[3] = 1'b0;
    wr(A_CTRL, cv(2'b01, 2'b01));
    @(negedge clk); pin_in[3] = 1'b1;
    settle(4);
    chk("R4 enabled", irq, 1);
    wr(A_CTRL, cv(2'b01, 2'b00));
    chk("R4 held", irq, 1);
    clear_all();
    @(negedge clk); pin_in[3] = 1'b0;
    settle(3);
  endtask

  task automatic t_remap();
    wr(A_SEL, {22'd0, 5'd19, 5'd14});
    wr(A_CTRL, cv(2'b11, 2'b11));
    @(negedge clk); pin_in[22] = 1'b1;
    settle(4);
    rdw(A_CTRL, rd); chk("R2 code14 pin22", rd[22:21], 2'b01);
    clear_all();
    wr(A_CTRL, cv(2'b11, 2'b11));
    @(negedge clk); pin_in[27] = 1'b1;
    settle(4);
    rdw(A_CTRL, rd); chk("R2 code19 pin27", rd[22:21], 2'b10);
    clear_all();
    rdw(A_SEL, rd); chk("R2 sel readback", rd, {22'd0, 5'd19, 5'd14});
    @(negedge clk); pin_in[22] = 1'b0; pin_in[27] = 1'b0;
    settle(3);
  endtask

  task automatic t_invalid();
    wr(A_SEL, {22'd0, 5'd31, 5'd20});
    wr(A_CTRL, cv(2'b11, 2'b11));
    @(negedge clk); pin_in = 28'hFFF_FFFF;
    settle(4);
    chk("R2 invalid code", irq, 0);
    @(negedge clk); pin_in = '0;
    settle(4);
    wr(A_SEL, {22'd0, 5'd0, 5'd14});
    @(negedge clk); pin_in[14] = 1'b1; pin_in[6] = 1'b1;
    settle(4);
    chk("R2 pin14 unreachable", irq, 0);
    @(negedge clk); pin_in = '0;
    settle(3);
  endtask

  task automatic t_polchange();
    @(negedge clk); pin_in[1] = 1'b1;
    wr(A_SEL, {22'd0, 5'd2, 5'd1});
    wr(A_CTRL, cv(2'b01, 2'b11));
    settle(4);
    clear_all();
    wr(A_CTRL, cv(2'b00, 2'b11));
    wr(A_CTRL, cv(2'b11, 2'b11));
    wr(A_SEL, {22'd0, 5'd1, 5'd2});
    settle(3);
    chk("R7 no spurious", irq, 0);
    @(negedge clk); pin_in[1] = 1'b0;
    settle(3);
  endtask

  task automatic t_setwins();
    wr(A_SEL, {22'd0, 5'd0, 5'd7});
    wr(A_CTRL, cv(2'b01, 2'b01));
    @(negedge clk); pin_in[7] = 1'b1;
    settle(4);
    @(negedge clk); pin_in[7] = 1'b0;
    settle(4);
    chk("R5 pre set", irq, 1);
    @(negedge clk); pin_in[7] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = A_CTRL; bus_we = 1'b1;
    bus_wdata = cv(2'b01, 2'b01) | 32'h0002_0000;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
    chk("R5 set wins", irq, 1);
    clear_all();
    chk("R5 clear after", irq, 0);
    @(negedge clk); pin_in[7] = 1'b0;
    settle(3);
  endtask

  task automatic t_busy();
    wr(A_CTRL, 32'h0001_0000);
    rdw(A_CTRL, rd); chk("R8 busy set", rd[16], 1);
    rdw(A_CTRL, rd); chk("R8 busy held", rd[16], 1);
    settle(8);
    rdw(A_CTRL, rd); chk("R8 busy cleared", rd[16], 0);
    wr(A_CTRL, 32'hFFFE_FFFF);
    rdw(A_CTRL, rd); chk("R9 unused zero", rd & 32'hFFFF_FF33, 0);
    wr(A_CTRL, 32'h0006_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_levels();
    t_rise();
    t_fall();
    t_enable();
    t_remap();
    t_invalid();
    t_polchange();
    t_setwins();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule